// File: doc/BRIEF.md
# Power-Up Command Gate for a Serial Flash Front End

This block sits between the serial shifter of a flash device and its command decoder, and it controls what happens while the supply comes up or goes away. A digital supply-good level enters through a two-flop synchronizer. While that level is low, every internal register is held cleared and no command gets a reply. Once the synchronized level is high, a cycle counter runs a fixed startup interval. One count serves both the read-allowed point and the write-allowed point. During that interval only the two status-polling opcodes are let through, and the write-in-progress flag reports busy.

When the interval ends, the device enters standby. The write-enable latch and both lock bits then hold their cleared defaults, and the interface protocol mode is captured from a nonvolatile configuration input. If chip select is already active when the supply becomes good, traffic in that selection is dropped silently. Replies resume only after chip select has been released once.

Each decoded command (`cmd_valid` with `cmd_op`) gets a one-cycle `cmd_accept` or `cmd_reject` pulse one clock later, or no reply at all when it is ignored.

Top module: `pwrup_gate`

## Requirements
- R1: While `supply_ok` is low, `ready`, `wip`, `wel`, `lock_wr` and `lock_down` are 0, and no command produces `cmd_accept` or `cmd_reject`.
- R2: Count as edge 0 the first rising clock edge at which `supply_ok` is high. `ready` is 0 after edges 0 through STARTUP_CYC, and it becomes 1 after edge STARTUP_CYC+1.
- R3: Before `ready`, a selected command (`cs_n` low) is accepted only if its opcode equals STAT_OP_A (default 8'h05) or STAT_OP_B (default 8'h70). Any other opcode is rejected. A reply is a one-cycle pulse on the clock edge after the edge that samples `cmd_valid`.
- R4: `wip` is 1 from the moment the synchronized supply is good until `ready` rises, and it is 0 afterwards.
- R5: `wel` is 0 during startup and in standby.
- R6: `lock_wr` and `lock_down` are both 0 once `ready` is 1.
- R7: Once `ready` is 1, every selected command is accepted, whatever its opcode.
- R8: `proto_mode` takes the value of `nv_proto` at the edge where `ready` rises. Later changes of `nv_proto` leave `proto_mode` unchanged.
- R9: A fall of `supply_ok` clears `ready` and every reply at once, without waiting for a clock edge. A later rise of `supply_ok` restarts the full interval.
- R10: If `cs_n` is low when the synchronized supply first becomes good, commands get no reply until `cs_n` has been seen high at one clock edge.
- R11: A command presented while `cs_n` is high gets no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_ok | input | 1 | Asynchronous supply-above-threshold level; low also acts as reset |
| cs_n | input | 1 | Chip select, active low |
| cmd_valid | input | 1 | A decoded opcode is present |
| cmd_op | input | OP_W | Decoded opcode |
| nv_proto | input | PROTO_W | Nonvolatile protocol-mode setting |
| cmd_accept | output | 1 | Command passed to the decoder |
| cmd_reject | output | 1 | Command refused |
| ready | output | 1 | Device fully accessible |
| wip | output | 1 | Write-in-progress status bit |
| wel | output | 1 | Write-enable latch status bit |
| lock_wr | output | 1 | Lock register write-lock bit |
| lock_down | output | 1 | Lock register lock-down bit |
| proto_mode | output | PROTO_W | Protocol mode captured at startup end |

## Verification
The bench builds the block with STARTUP_CYC set to 40 and keeps the default status opcodes and widths. Forty cycles is long enough to fit a blocked selection, a chip-select release, and a full set of status and non-status commands inside one startup window. It is also short enough to time the exact `ready` edge and to cover two supply drops, one during standby and one during startup, within a short run.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  // True when the opcode is one of the two status-polling reads
  function automatic logic is_poll_op(input logic [7:0] op,
                                      input logic [7:0] op_a,
                                      input logic [7:0] op_b);
    return (op == op_a) || (op == op_b);
  endfunction

  // Counter width able to hold the value lim
  function automatic int cnt_width(input int lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/pwrup_sync.sv
module pwrup_sync (
  input  logic clk,
  input  logic supply_ok,
  output logic run
);
  logic meta_q, run_q;

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      meta_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      run_q  <= meta_q;
    end
  end

  assign run = run_q;

  // R9: run can only be high while the raw supply is good
  always @(posedge clk) begin
    if (supply_ok === 1'b0)
      a_r9_run_follows_supply: assert (run_q !== 1'b1);
  end
endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int STARTUP_CYC = 1000
) (
  input  logic clk,
  input  logic run,
  output logic ready
);
  import pwrup_pkg::*;
  localparam int CW = cnt_width(STARTUP_CYC);
  localparam logic [CW-1:0] LIMIT = CW'(STARTUP_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge run) begin
    if (!run)                cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready = (cnt_q == LIMIT);

  // R2: counter never passes its limit
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!run)
    cnt_q <= LIMIT);
  // R4: once accessible, stays accessible until power is lost
  a_r4_ready_sticky: assert property (@(posedge clk) disable iff (!run)
    ready |=> ready);
endmodule

// File: rtl/pwrup_cmd_filter.sv
module pwrup_cmd_filter #(
  parameter int          OP_W      = 8,
  parameter logic [7:0]  STAT_OP_A = 8'h05,
  parameter logic [7:0]  STAT_OP_B = 8'h70
) (
  input  logic            clk,
  input  logic            run,
  input  logic            ready,
  input  logic            cs_n,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  output logic            cmd_accept,
  output logic            cmd_reject,
  output logic            sel_blocked
);
  import pwrup_pkg::*;

  logic block_q, acc_q, rej_q;
  logic live_cmd, poll_hit, pass;

  // Blocked from reset until chip select is seen released
  always_ff @(posedge clk or negedge run) begin
    if (!run)      block_q <= 1'b1;
    else if (cs_n) block_q <= 1'b0;
  end

  assign poll_hit = is_poll_op(8'(cmd_op), STAT_OP_A, STAT_OP_B);
  assign live_cmd = cmd_valid && !cs_n && !block_q;
  assign pass     = ready || poll_hit;

  always_ff @(posedge clk or negedge run) begin
    if (!run) begin
      acc_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      acc_q <= live_cmd && pass;
      rej_q <= live_cmd && !pass;
    end
  end

  assign cmd_accept  = acc_q;
  assign cmd_reject  = rej_q;
  assign sel_blocked = block_q;

  // R3: a non-status opcode before ready is never accepted
  a_r3_startup_filter: assert property (@(posedge clk) disable iff (!run)
    (cmd_valid && !ready && !poll_hit) |=> !cmd_accept);
  // R7: after ready a selected, unblocked command is accepted
  a_r7_accept_all: assert property (@(posedge clk) disable iff (!run)
    (cmd_valid && !cs_n && !block_q && ready) |=> cmd_accept);
  // R10: a blocked selection yields no reply
  a_r10_blocked_silent: assert property (@(posedge clk) disable iff (!run)
    (block_q && cmd_valid) |=> !(cmd_accept || cmd_reject));
  // R11: deselected commands yield no reply
  a_r11_deselected: assert property (@(posedge clk) disable iff (!run)
    (cs_n && cmd_valid) |=> !(cmd_accept || cmd_reject));
  // R3: accept and reject are exclusive
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!run)
    !(cmd_accept && cmd_reject));
endmodule

// File: rtl/pwrup_gate.sv
module pwrup_gate #(
  parameter int          STARTUP_CYC = 1000,
  parameter int          OP_W        = 8,
  parameter int          PROTO_W     = 2,
  parameter logic [7:0]  STAT_OP_A   = 8'h05,
  parameter logic [7:0]  STAT_OP_B   = 8'h70
) (
  input  logic               clk,
  input  logic               supply_ok,
  input  logic               cs_n,
  input  logic               cmd_valid,
  input  logic [OP_W-1:0]    cmd_op,
  input  logic [PROTO_W-1:0] nv_proto,
  output logic               cmd_accept,
  output logic               cmd_reject,
  output logic               ready,
  output logic               wip,
  output logic               wel,
  output logic               lock_wr,
  output logic               lock_down,
  output logic [PROTO_W-1:0] proto_mode
);
  logic run, sel_blocked;
  logic wel_q, lock_wr_q, lock_dn_q;
  logic [PROTO_W-1:0] proto_q;

  pwrup_sync u_sync (.clk(clk), .supply_ok(supply_ok), .run(run));

  pwrup_timer #(.STARTUP_CYC(STARTUP_CYC)) u_timer (
    .clk(clk), .run(run), .ready(ready));

  pwrup_cmd_filter #(.OP_W(OP_W), .STAT_OP_A(STAT_OP_A), .STAT_OP_B(STAT_OP_B))
  u_filter (
    .clk(clk), .run(run), .ready(ready), .cs_n(cs_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
    .sel_blocked(sel_blocked));

  // Status and lock defaults; mode tracks config until the ready edge
  always_ff @(posedge clk or negedge run) begin
    if (!run) begin
      wel_q     <= 1'b0;
      lock_wr_q <= 1'b0;
      lock_dn_q <= 1'b0;
      proto_q   <= '0;
    end else if (!ready) begin
      wel_q     <= 1'b0;
      lock_wr_q <= 1'b0;
      lock_dn_q <= 1'b0;
      proto_q   <= nv_proto;
    end
  end

  assign wip        = run && !ready;
  assign wel        = wel_q;
  assign lock_wr    = lock_wr_q;
  assign lock_down  = lock_dn_q;
  assign proto_mode = proto_q;

  // R1: no reply while the synchronized supply is low
  always @(posedge clk) begin
    if (run === 1'b0)
      a_r1_quiet_down: assert (!(cmd_accept === 1'b1 || cmd_reject === 1'b1));
  end
  // R5: write-enable latch clear while busy or in standby
  a_r5_wel_clear: assert property (@(posedge clk) disable iff (!run)
    (wip || ready) |-> !wel);
  // R6: lock bits clear once accessible
  a_r6_locks_clear: assert property (@(posedge clk) disable iff (!run)
    ready |-> !(lock_wr || lock_down));
  // R8: captured mode frozen during standby
  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!run)
    ($past(ready) && ready) |-> $stable(proto_mode));
  // R4: busy flag clear in the cycle after ready
  a_r4_wip_done: assert property (@(posedge clk) disable iff (!run)
    ready |=> !wip);
endmodule

// File: tb/pwrup_gate_bench.sv
module pwrup_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 40;

  logic       clk = 1'b0;
  logic       supply_ok, cs_n, cmd_valid;
  logic [7:0] cmd_op;
  logic [1:0] nv_proto;
  logic       cmd_accept, cmd_reject, ready, wip, wel, lock_wr, lock_down;
  logic [1:0] proto_mode;

  int checks = 0, failures = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrup_gate #(.STARTUP_CYC(N)) u_pwrup_gate (
    .clk(clk), .supply_ok(supply_ok), .cs_n(cs_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .nv_proto(nv_proto), .cmd_accept(cmd_accept),
    .cmd_reject(cmd_reject), .ready(ready), .wip(wip), .wel(wel),
    .lock_wr(lock_wr), .lock_down(lock_down), .proto_mode(proto_mode));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: one command, expected {accept,reject} pushed to the scoreboard
  task automatic send(input logic [7:0] op, input logic acc, input logic rej,
                      input string tag);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    exp_q.push_back({acc, rej});
    tag_q.push_back(tag);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Monitor: compares the reply registered at the edge after the command
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {6'd0, cmd_accept, cmd_reject}, {6'd0, e});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    supply_ok = 1'b0; cs_n = 1'b1; cmd_valid = 1'b0; cmd_op = 8'h00;
    nv_proto = 2'b10;
    repeat (3) @(negedge clk);
    chk("R1 ready down", {7'd0, ready}, 8'd0);
    chk("R1 wip down", {7'd0, wip}, 8'd0);
    chk("R1 wel down", {7'd0, wel}, 8'd0);
    chk("R1 locks down", {6'd0, lock_wr, lock_down}, 8'd0);
    cs_n = 1'b0;
    send(8'h05, 1'b0, 1'b0, "R1 cmd while down");
    cs_n = 1'b1;

    // Power-up A: exact ready timing
    @(negedge clk);
    supply_ok = 1'b1;
    repeat (N + 1) @(posedge clk);
    #1;
    chk("R2 ready not yet", {7'd0, ready}, 8'd0);
    chk("R4 wip busy", {7'd0, wip}, 8'd1);
    @(posedge clk);
    #1;
    chk("R2 ready edge", {7'd0, ready}, 8'd1);
    chk("R4 wip cleared", {7'd0, wip}, 8'd0);
    chk("R6 locks cleared", {6'd0, lock_wr, lock_down}, 8'd0);
    chk("R5 wel standby", {7'd0, wel}, 8'd0);
    chk("R8 mode captured", {6'd0, proto_mode}, 8'd2);
    nv_proto = 2'b01;
    repeat (3) @(negedge clk);
    chk("R8 mode frozen", {6'd0, proto_mode}, 8'd2);
    cs_n = 1'b0;
    send(8'h02, 1'b1, 1'b0, "R7 program op");
    send(8'h9F, 1'b1, 1'b0, "R7 id op");
    send(8'h05, 1'b1, 1'b0, "R7 status op");
    cs_n = 1'b1;
    send(8'h02, 1'b0, 1'b0, "R11 deselected");

    // Drop during standby
    @(negedge clk);
    supply_ok = 1'b0;
    #1;
    chk("R9 ready drop", {7'd0, ready}, 8'd0);
    cs_n = 1'b0;
    send(8'h05, 1'b0, 1'b0, "R9 no reply after drop");

    // Power-up B with chip select held low
    @(negedge clk);
    supply_ok = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 wip startup", {7'd0, wip}, 8'd1);
    chk("R5 wel startup", {7'd0, wel}, 8'd0);
    send(8'h05, 1'b0, 1'b0, "R10 blocked status");
    send(8'h02, 1'b0, 1'b0, "R10 blocked other");
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    send(8'h05, 1'b1, 1'b0, "R3 status A");
    send(8'h70, 1'b1, 1'b0, "R3 status B");
    send(8'h02, 1'b0, 1'b1, "R3 program rejected");
    send(8'hD8, 1'b0, 1'b1, "R3 erase rejected");
    cs_n = 1'b1;
    send(8'h05, 1'b0, 1'b0, "R11 deselected startup");
    chk("R2 still starting", {7'd0, ready}, 8'd0);

    // Drop during startup, then restart full interval
    @(negedge clk);
    supply_ok = 1'b0;
    #1;
    chk("R9 wip drop", {7'd0, wip}, 8'd0);
    @(negedge clk);
    supply_ok = 1'b1;
    repeat (N + 1) @(posedge clk);
    #1;
    chk("R9 restart not ready", {7'd0, ready}, 8'd0);
    @(posedge clk);
    #1;
    chk("R9 restart ready", {7'd0, ready}, 8'd1);
    chk("R8 new mode", {6'd0, proto_mode}, 8'd1);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule